// File: doc/BRIEF.md
# Programmable Watchdog Timer Unit

This block guards a processor against runaway software. Once started, a 15-bit up-counter advances at a prescaled fraction of the machine-clock enable. Software must restart it before it reaches its top value. If it does not, the counter overflows. The block then raises a one-cycle reset request and puts itself back into its post-reset configuration. A sticky flag records that the watchdog was the cause of that reset.

Software reaches the block through a simple write strobe with a one-bit address. Address 0 holds the configuration: a 7-bit restart value for the upper counter bits and a prescaler select bit. Address 1 is the control word. It carries the start bit, the two bits of the restart handshake and the flag-keep bit. A restart only counts when an arm write is followed by a trigger write as the very next register write. Any other write in between cancels the handshake.

The sequencing is a four-state machine. IDLE means stopped. COUNT means running and not armed. ARMED means running with the first half of the handshake seen. BITE is the single cycle that issues the reset request. The transitions are:
- start: IDLE to COUNT.
- arm: COUNT to ARMED.
- refresh: ARMED to COUNT on a trigger write.
- cancel: ARMED to COUNT on any other write that is not an arm write.
- rearm: ARMED to ARMED on an arm write.
- expire: COUNT or ARMED to BITE on overflow.
- recover: BITE to IDLE.

Top module: `wdog_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, `count_o` is 0, `running` is 0, `wdt_rst_req` is 0 and `wdt_flag` is 0.
- R2: A write to address 1 with bit 0 set starts the timer, so `running` is 1 after that edge. A later control write with bit 0 clear does not stop it. Only overflow or `rst_n` stops it.
- R3: The counter holds while stopped. While running with select bit clear, it advances once per 2 `mach_tick` pulses. With select bit set, it advances once per 32 pulses. The prescaler starts from zero at start and at each refresh.
- R4: A refresh happens only while running. An arm write (address 1, bit 1 = 1, bit 2 = 0) must be followed by a trigger write (address 1, bit 2 = 1, bit 1 = 0) as the next register write. Cycles with no write may come between them. On a refresh, counter bits 14..8 take the reload value and bits 7..0 become 0.
- R5: A trigger write that is not preceded by an arm write leaves the counter unchanged. So does a trigger write preceded by an arm write when some other write came between them.
- R6: An advance from 0x7FFF (with no refresh on the same edge) makes `wdt_rst_req` 1 for exactly one cycle, right after that edge.
- R7: In the cycle `wdt_rst_req` is 1, `count_o` is 0 and `running` is 0. The reload value and select bit are 0 from then on.
- R8: `wdt_flag` rises only together with `wdt_rst_req`. It persists through the watchdog reset. A control write with bit 3 = 1 keeps it. A control write with bit 3 = 0 clears it. `rst_n` low clears it.
- R9: A write to address 0 stores bits 6..0 as the reload value and bit 7 as the prescaler select. It does not alter the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous |
| mach_tick | input | 1 | Machine-clock count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration, 1 = control |
| wr_data | input | 8 | Write data |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| wdt_flag | output | 1 | Sticky watchdog-reset status |
| running | output | 1 | Timer started |
| count_o | output | 15 | Current counter value |

## Verification
A stuck or wrongly advanced FSM state appears at `running` on the next cycle, or as a refresh that fails to reload `count_o` on the edge after the trigger write. A prescaler phase error shows as a counter value off by one a few ticks after a refresh. It also moves the reset request by whole prescale periods, which the bench catches by checking `wdt_rst_req` one tick before and exactly at the computed overflow. A lost clear of configuration or flag becomes visible at the next refresh after a watchdog reset, as a wrong reload, or on the next read of `wdt_flag`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W  = 15;
    localparam int RLD_W  = 7;
    localparam int LOW_W  = CNT_W - RLD_W;
    localparam int DATA_W = RLD_W + 1;
    localparam int SEL_BIT = RLD_W;

    // control word bit positions
    localparam int CTL_START = 0;
    localparam int CTL_ARM   = 1;
    localparam int CTL_TRIG  = 2;
    localparam int CTL_KEEP  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ARMED = 2'd2,
        ST_BITE  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int FINE_DIV   = 2,
    parameter int COARSE_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    input  logic sel,
    output logic inc
);
    localparam int TOTAL = FINE_DIV * COARSE_DIV;
    localparam int PW    = $clog2(TOTAL);
    localparam int FW    = $clog2(FINE_DIV);

    logic [PW-1:0] pre_q;
    logic          fine_end;

    generate
        if (FW == 0) begin : g_nofine
            assign fine_end = 1'b1;
        end else begin : g_fine
            assign fine_end = &pre_q[FW-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (run && tick)
            pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        inc = run && tick && (sel ? (&pre_q) : fine_end);
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [RLD_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= {load_val, {LOW_W{1'b0}}};
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        cnt  = cnt_q;
        wrap = inc && (&cnt_q);
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wrap,
    output logic              running,
    output logic              fire,
    output logic              refresh,
    output logic              rst_req,
    output logic              flag,
    output logic [RLD_W-1:0]  rld_val,
    output logic              sel
);
    wd_state_e        state_q, state_d;
    logic [RLD_W-1:0] rld_q;
    logic             sel_q, flag_q;
    logic             ctl_wr, cfg_wr, arm_wr, trg_wr, start_wr;

    always_comb begin
        ctl_wr   = wr_en && wr_addr;
        cfg_wr   = wr_en && !wr_addr;
        start_wr = ctl_wr && wr_data[CTL_START];
        arm_wr   = ctl_wr && wr_data[CTL_ARM] && !wr_data[CTL_TRIG];
        trg_wr   = ctl_wr && wr_data[CTL_TRIG] && !wr_data[CTL_ARM];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_wr) state_d = ST_COUNT;
            ST_COUNT: begin
                if (wrap)        state_d = ST_BITE;
                else if (arm_wr) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (trg_wr)      state_d = ST_COUNT;
                else if (wrap)   state_d = ST_BITE;
                else if (arm_wr) state_d = ST_ARMED;
                else if (wr_en)  state_d = ST_COUNT;
            end
            ST_BITE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        running = 1'b0;
        rst_req = 1'b0;
        refresh = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_COUNT: begin
                running = 1'b1;
                fire    = wrap;
            end
            ST_ARMED: begin
                running = 1'b1;
                refresh = trg_wr;
                fire    = wrap && !trg_wr;
            end
            ST_BITE:  rst_req = 1'b1;
            default:  ;
        endcase
    end

    // configuration and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q  <= '0;
            sel_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (fire) begin
            rld_q  <= '0;
            sel_q  <= 1'b0;
            flag_q <= 1'b1;
        end else if (state_q != ST_BITE) begin
            if (cfg_wr) begin
                rld_q <= wr_data[RLD_W-1:0];
                sel_q <= wr_data[SEL_BIT];
            end
            if (ctl_wr && !wr_data[CTL_KEEP])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        flag    = flag_q;
        rld_val = rld_q;
        sel     = sel_q;
    end
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
    import wdog_pkg::*;
#(
    parameter int FINE_DIV   = 2,
    parameter int COARSE_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mach_tick,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdt_rst_req,
    output logic              wdt_flag,
    output logic              running,
    output logic [CNT_W-1:0]  count_o
);
    logic             run_s, fire_s, refresh_s, inc_s, wrap_s, sel_s;
    logic [RLD_W-1:0] rld_s;

    wdog_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrap    (wrap_s),
        .running (run_s),
        .fire    (fire_s),
        .refresh (refresh_s),
        .rst_req (wdt_rst_req),
        .flag    (wdt_flag),
        .rld_val (rld_s),
        .sel     (sel_s)
    );

    wdog_prescale #(
        .FINE_DIV   (FINE_DIV),
        .COARSE_DIV (COARSE_DIV)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (refresh_s || fire_s),
        .run   (run_s),
        .tick  (mach_tick),
        .sel   (sel_s),
        .inc   (inc_s)
    );

    wdog_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fire_s),
        .load     (refresh_s),
        .load_val (rld_s),
        .inc      (inc_s),
        .cnt      (count_o),
        .wrap     (wrap_s)
    );

    assign running = run_s;
endmodule

// File: rtl/wdog_unit_chk.sv
module wdog_unit_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             rst_req,
    input logic             flag,
    input logic [CNT_W-1:0] count
);
    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7
    bite_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0) && !running && flag);

    // R2
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running || rst_req);

    // R3
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(count));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (count == $past(count)) || (count == $past(count) + 1'b1)
                    || (count[LOW_W-1:0] == '0));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> rst_req);
endmodule

bind wdog_unit wdog_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .rst_req (wdt_rst_req),
    .flag    (wdt_flag),
    .count   (count_o)
);

// File: tb/wdog_unit_test.sv
module wdog_unit_test;
    import wdog_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n, tick, we, addr;
    logic [DATA_W-1:0] data;
    logic              req, flag, run;
    logic [CNT_W-1:0]  cnt;
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    wdog_unit uut (
        .clk (clk), .rst_n (rst_n), .mach_tick (tick),
        .wr_en (we), .wr_addr (addr), .wr_data (data),
        .wdt_rst_req (req), .wdt_flag (flag), .running (run), .count_o (cnt)
    );

    function automatic int exp_count(int r, int k, bit sel);
        return (r << 8) + k / (sel ? 32 : 2);
    endfunction

    function automatic int timeout_ticks(int r, bit sel);
        return (128 - r) * 256 * (sel ? 32 : 2);
    endfunction

    task automatic chk(string req_tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req_tag, what, got, exp);
        end
    endtask

    task automatic cyc(bit tk, bit w, bit a, logic [DATA_W-1:0] d);
        tick = tk; we = w; addr = a; data = d;
        @(negedge clk);
        tick = 1'b0; we = 1'b0; addr = 1'b0; data = '0;
    endtask

    task automatic wr(bit a, logic [DATA_W-1:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic idle(int n);
        repeat (n) cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic run_ticks(int n, bit rnd);
        int got = 0;
        while (got < n) begin
            bit t = rnd ? 1'($urandom % 2) : 1'b1;
            cyc(t, 1'b0, 1'b0, '0);
            if (t) got++;
        end
    endtask

    task automatic refresh_seq();
        wr(1'b1, 8'h0A);
        wr(1'b1, 8'h0C);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = 1'b0; data = '0;
        idle(3);
        chk("R1", "count in reset", int'(cnt), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1", "count", int'(cnt), 0);
        chk("R1", "running", int'(run), 0);
        chk("R1", "req", int'(req), 0);
        chk("R1", "flag", int'(flag), 0);

        run_ticks(10, 1'b0);
        chk("R3", "holds while stopped", int'(cnt), 0);

        wr(1'b1, 8'h09);
        chk("R2", "started", int'(run), 1);
        run_ticks(37, 1'b1);
        chk("R3", "fine rate", int'(cnt), exp_count(0, 37, 1'b0));
        wr(1'b1, 8'h08);
        chk("R2", "cannot stop", int'(run), 1);

        wr(1'b0, 8'h7E);
        chk("R9", "config write leaves count", int'(cnt), exp_count(0, 37, 1'b0));
        refresh_seq();
        chk("R4", "refresh loads reload", int'(cnt), 'h7E00);

        wr(1'b1, 8'h0A);
        wr(1'b0, 8'h7F);
        wr(1'b1, 8'h0C);
        chk("R5", "broken sequence ignored", int'(cnt), 'h7E00);

        wr(1'b1, 8'h0A);
        idle(3);
        wr(1'b1, 8'h0C);
        chk("R4", "idle gap allowed", int'(cnt), 'h7F00);

        run_ticks(10, 1'b1);
        chk("R3", "count after refresh", int'(cnt), exp_count(127, 10, 1'b0));
        wr(1'b1, 8'h0C);
        chk("R5", "lone trigger ignored", int'(cnt), exp_count(127, 10, 1'b0));

        run_ticks(timeout_ticks(127, 1'b0) - 10 - 1, 1'b1);
        chk("R6", "no req before overflow", int'(req), 0);
        chk("R6", "top value", int'(cnt), 'h7FFF);
        run_ticks(1, 1'b0);
        chk("R6", "req at overflow", int'(req), 1);
        chk("R7", "count cleared", int'(cnt), 0);
        chk("R7", "stopped", int'(run), 0);
        chk("R8", "flag set", int'(flag), 1);
        idle(1);
        chk("R6", "req one cycle", int'(req), 0);
        chk("R8", "flag survives", int'(flag), 1);

        wr(1'b1, 8'h09);
        refresh_seq();
        chk("R7", "reload cleared", int'(cnt), 0);
        run_ticks(4, 1'b0);
        chk("R7", "select cleared", int'(cnt), 2);

        wr(1'b0, 8'hFF);
        refresh_seq();
        run_ticks(31, 1'b1);
        chk("R3", "coarse hold", int'(cnt), 'h7F00);
        run_ticks(1, 1'b1);
        chk("R3", "coarse step", int'(cnt), 'h7F01);
        run_ticks(timeout_ticks(127, 1'b1) - 32 - 1, 1'b1);
        chk("R6", "coarse no early req", int'(req), 0);
        run_ticks(1, 1'b0);
        chk("R6", "coarse req", int'(req), 1);

        idle(1);
        wr(1'b1, 8'h08);
        chk("R8", "keep bit", int'(flag), 1);
        wr(1'b1, 8'h00);
        chk("R8", "write zero clears", int'(flag), 0);

        wr(1'b1, 8'h01);
        run_ticks(timeout_ticks(0, 1'b0) - 1, 1'b0);
        chk("R6", "longest no req", int'(req), 0);
        chk("R6", "longest top", int'(cnt), 'h7FFF);
        run_ticks(1, 1'b0);
        chk("R6", "longest req", int'(req), 1);
        chk("R8", "flag from longest", int'(flag), 1);

        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        chk("R8", "hw reset clears flag", int'(flag), 0);
        chk("R1", "stopped after hw reset", int'(run), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule